// File: doc/BRIEF.md
# Board Interrupt Aggregator with Socket Status

This block sits on a simple word-wide register bus and collects sixteen level-type interrupt lines from the board. Each enabled line that goes from low to high sets a bit in a pending register. A mask-enable register decides which lines may latch and which pending bits reach the single parent interrupt output. Software services an interrupt by rewriting the pending register directly. The new word replaces the old contents, so the same write can clear some bits and set others.

Two of the interrupt lines also report card presence for two card sockets. Line 9 drives the active-low detect bit of socket 0, and line 13 drives the detect bit of socket 1. Each socket status word also holds a ready flag and five control bits for power and reset. Software may change only those five control bits. The block also holds eight plain 32-bit storage words for LED data, LED control, switches and miscellaneous board settings. Every access uses a byte offset, and reads return data through a registered read port.

Top module: `board_irq_ctrl`

## Requirements
- R1: After synchronous reset, `rd_data` and `irq_out` are 0. Every register reads 0 except the two socket status words, which read 0x0000_0420 (ready bit 10 and detect bit 5 set).
- R2: The words at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90 are plain 32-bit read/write storage.
- R3: `rd_data` shows, one clock after an edge, the register addressed by `bus_addr` at that edge. A write on the same edge is not yet visible in that read.
- R4: A pending bit is set only on a low-to-high change of its input, sampled at the clock, while its mask-enable bit (offset 0xC0) already holds 1. A mask write on the same edge does not enable that edge.
- R5: Writes to the mask-enable register (0xC0) and the pending register (0xD0) keep only the bits in 0x000F_EEFF. All other bits become 0.
- R6: A write to the pending register (0xD0) replaces its contents with the filtered data. A latch event on the same edge still sets its bit.
- R7: `irq_out` is registered. It is 1 exactly when the AND of the pending and mask-enable registers, as they stood one clock earlier, is nonzero.
- R8: Bit 5 of socket 0 status (0xE0) is the inverse of `irq_in[9]`, and bit 5 of socket 1 status (0xE4) is the inverse of `irq_in[13]`. Each follows its input one clock later.
- R9: A write to a socket status word changes only bits 4:0, and all higher bits keep their values.
- R10: A read from an offset outside the map returns 0, and a write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| irq_in | input | N_IRQ | Level interrupt inputs |
| rd_data | output | 32 | Registered read data for the address of the previous edge |
| irq_out | output | 1 | Registered parent interrupt |

## Verification
Two events can fall on the same edge. One is a software write to the pending or mask-enable register, and the other is a rising edge on an enabled interrupt input. Directed cases provoke this on purpose: a pending write that clears a bit on the edge where its line rises, and a mask write that enables a line on the edge where that line rises. Random traffic mixes register writes with toggling inputs so that such collisions recur. A bench model applies the latch-wins and mask-already-set rules, and the pending word, the mask-enable word and `irq_out` are compared against that model on every cycle.

// File: rtl/brd_pkg.sv
package brd_pkg;

  localparam int unsigned DW     = 32;
  localparam int unsigned N_IRQ  = 16;
  localparam int unsigned N_GP   = 8;
  localparam int unsigned GP_IW  = $clog2(N_GP);
  localparam int unsigned N_SOCK = 2;

  // bits that survive a write into mask-enable or pending
  localparam logic [DW-1:0] IRQ_KEEP = 32'h000F_EEFF;

  localparam logic [31:0] OFF_LED_A   = 32'h10;
  localparam logic [31:0] OFF_LED_B   = 32'h14;
  localparam logic [31:0] OFF_LED_CTL = 32'h40;
  localparam logic [31:0] OFF_SWITCH  = 32'h60;
  localparam logic [31:0] OFF_AUX0    = 32'h80;
  localparam logic [31:0] OFF_AUX1    = 32'h84;
  localparam logic [31:0] OFF_AUX2    = 32'h88;
  localparam logic [31:0] OFF_AUXIN   = 32'h90;
  localparam logic [31:0] OFF_MASK    = 32'hC0;
  localparam logic [31:0] OFF_PEND    = 32'hD0;
  localparam logic [31:0] OFF_SOCK0   = 32'hE0;
  localparam logic [31:0] OFF_SOCK1   = 32'hE4;

  typedef struct packed {
    logic              hit;
    logic              gp;
    logic [GP_IW-1:0]  gp_idx;
    logic              mask;
    logic              pend;
    logic [N_SOCK-1:0] sock;
  } dec_t;

  function automatic dec_t decode(input logic [31:0] a);
    dec_t d;
    d = '0;
    d.hit = 1'b1;
    case (a)
      OFF_LED_A:   begin d.gp = 1'b1; d.gp_idx = GP_IW'(0); end
      OFF_LED_B:   begin d.gp = 1'b1; d.gp_idx = GP_IW'(1); end
      OFF_LED_CTL: begin d.gp = 1'b1; d.gp_idx = GP_IW'(2); end
      OFF_SWITCH:  begin d.gp = 1'b1; d.gp_idx = GP_IW'(3); end
      OFF_AUX0:    begin d.gp = 1'b1; d.gp_idx = GP_IW'(4); end
      OFF_AUX1:    begin d.gp = 1'b1; d.gp_idx = GP_IW'(5); end
      OFF_AUX2:    begin d.gp = 1'b1; d.gp_idx = GP_IW'(6); end
      OFF_AUXIN:   begin d.gp = 1'b1; d.gp_idx = GP_IW'(7); end
      OFF_MASK:    d.mask = 1'b1;
      OFF_PEND:    d.pend = 1'b1;
      OFF_SOCK0:   d.sock[0] = 1'b1;
      OFF_SOCK1:   d.sock[1] = 1'b1;
      default:     d.hit = 1'b0;
    endcase
    return d;
  endfunction

  // interrupt input that mirrors into each socket's detect bit
  function automatic int unsigned sock_irq(input int unsigned s);
    return (s == 0) ? 9 : 13;
  endfunction

endpackage

// File: rtl/gp_reg_bank.sv
module gp_reg_bank #(
  parameter int unsigned N_REGS = 8,
  parameter int unsigned DW     = 32,
  localparam int unsigned IW    = $clog2(N_REGS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IW-1:0]             wr_idx,
  input  logic [DW-1:0]             wdata,
  output logic [N_REGS-1:0][DW-1:0] regs
);

  for (genvar g = 0; g < N_REGS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (wr_en && (wr_idx == IW'(g)))
        regs[g] <= wdata;
    end

    // R2: a word changes only when it is the addressed write target
    a_r2_word_hold: assert property (@(posedge clk) disable iff (rst || $past(rst))
      !($past(wr_en) && ($past(wr_idx) == IW'(g))) |-> regs[g] == $past(regs[g]));
  end

endmodule

// File: rtl/irq_pending_unit.sv
module irq_pending_unit #(
  parameter int unsigned N_IN      = 16,
  parameter int unsigned DW        = 32,
  parameter logic [DW-1:0] KEEP    = 32'h000F_EEFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] irq_in,
  input  logic            mask_wr,
  input  logic            pend_wr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   mask_q,
  output logic [DW-1:0]   pend_q,
  output logic            irq_out
);

  logic [N_IN-1:0] prev_q;
  logic [N_IN-1:0] rise;
  logic [DW-1:0]   rise_w;
  logic [DW-1:0]   pend_n;

  // only lines whose enable is already set may latch
  assign rise   = irq_in & ~prev_q & mask_q[N_IN-1:0];
  assign rise_w = DW'(rise);

  always_comb begin
    if (pend_wr)
      pend_n = (wdata & KEEP) | rise_w;
    else
      pend_n = pend_q | rise_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      mask_q  <= '0;
      pend_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      prev_q  <= irq_in;
      pend_q  <= pend_n;
      irq_out <= |(pend_q & mask_q);
      if (mask_wr)
        mask_q <= wdata & KEEP;
    end
  end

  // R4: a newly set pending bit had its enable set on the previous edge
  a_r4_enabled_only: assert property (@(posedge clk) disable iff (rst || $past(rst))
    !$past(pend_wr) |-> ((pend_q & ~$past(pend_q) & ~$past(mask_q)) == '0));

  // R5: bits outside the keep set never appear in mask or pending
  a_r5_keep_bits: assert property (@(posedge clk) disable iff (rst)
    ((mask_q | pend_q) & ~KEEP) == '0);

  // R6: a latch event survives a pending write on the same edge
  a_r6_latch_wins: assert property (@(posedge clk) disable iff (rst || $past(rst))
    $past(pend_wr) |-> ((pend_q & $past(rise_w)) == $past(rise_w)));

  // R7: parent line follows the masked pending word one edge later
  a_r7_out_delay: assert property (@(posedge clk) disable iff (rst || $past(rst))
    $rose(irq_out) |-> ($past(pend_q & mask_q) != '0));

endmodule

// File: rtl/sock_status_reg.sv
module sock_status_reg #(
  parameter int unsigned DW      = 32,
  parameter int unsigned CTRL_W  = 5,
  parameter int unsigned CD_BIT  = 5,
  parameter int unsigned RDY_BIT = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wctrl,
  input  logic              cd_in,
  output logic [DW-1:0]     stat
);

  localparam logic [DW-1:0] RST_VAL = (DW'(1) << RDY_BIT) | (DW'(1) << CD_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= RST_VAL;
    end else begin
      stat[CD_BIT] <= ~cd_in;
      if (wr)
        stat[CTRL_W-1:0] <= wctrl;
    end
  end

  // R8: detect bit is the inverted input from one edge earlier
  a_r8_detect: assert property (@(posedge clk) disable iff (rst || $past(rst))
    stat[CD_BIT] == !$past(cd_in));

  // R9: bits above the control field never change after reset
  a_r9_upper_hold: assert property (@(posedge clk) disable iff (rst || $past(rst))
    stat[DW-1:CD_BIT+1] == $past(stat[DW-1:CD_BIT+1]));

endmodule

// File: rtl/board_irq_ctrl.sv
module board_irq_ctrl #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned N_IRQ  = brd_pkg::N_IRQ
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic [N_IRQ-1:0]  irq_in,
  output logic [31:0]       rd_data,
  output logic              irq_out
);
  import brd_pkg::*;

  localparam int unsigned CTRL_W = 5;

  dec_t                         dec;
  logic [N_GP-1:0][DW-1:0]      gp_regs;
  logic [N_SOCK-1:0][DW-1:0]    sock_stat;
  logic [DW-1:0]                mask_q;
  logic [DW-1:0]                pend_q;
  logic [DW-1:0]                rd_n;

  assign dec = decode(32'(bus_addr));

  gp_reg_bank #(.N_REGS(N_GP), .DW(DW)) u_gp (
    .clk(clk), .rst(rst),
    .wr_en(bus_wr && dec.gp), .wr_idx(dec.gp_idx),
    .wdata(bus_wdata), .regs(gp_regs)
  );

  irq_pending_unit #(.N_IN(N_IRQ), .DW(DW), .KEEP(IRQ_KEEP)) u_irq (
    .clk(clk), .rst(rst), .irq_in(irq_in),
    .mask_wr(bus_wr && dec.mask), .pend_wr(bus_wr && dec.pend),
    .wdata(bus_wdata), .mask_q(mask_q), .pend_q(pend_q), .irq_out(irq_out)
  );

  for (genvar s = 0; s < N_SOCK; s++) begin : g_sock
    localparam int unsigned LINE = sock_irq(s);
    sock_status_reg #(.DW(DW), .CTRL_W(CTRL_W), .CD_BIT(5), .RDY_BIT(10)) u_stat (
      .clk(clk), .rst(rst),
      .wr(bus_wr && dec.sock[s]), .wctrl(bus_wdata[CTRL_W-1:0]),
      .cd_in(irq_in[LINE]), .stat(sock_stat[s])
    );
  end

  always_comb begin
    rd_n = '0;
    if (dec.gp)   rd_n = gp_regs[dec.gp_idx];
    if (dec.mask) rd_n = mask_q;
    if (dec.pend) rd_n = pend_q;
    for (int s = 0; s < N_SOCK; s++)
      if (dec.sock[s]) rd_n = sock_stat[s];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_n;
  end

  // R10: an unmapped address reads back as zero
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst || $past(rst))
    $past(!dec.hit) |-> rd_data == '0);

  // R3: a mapped read of the pending word returns the value held at the edge
  a_r3_read_pend: assert property (@(posedge clk) disable iff (rst || $past(rst))
    $past(dec.pend) |-> rd_data == $past(pend_q));

endmodule

// File: tb/board_irq_ctrl_tb_top.sv
module board_irq_ctrl_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 12;
  localparam logic [31:0] KEEP = 32'h000F_EEFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [15:0] irq_in = '0;
  logic [31:0] rd_data;
  logic irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] m_gp [8];
  logic [31:0] m_mask, m_pend;
  logic [31:0] m_sock [2];
  logic [15:0] m_prev;
  logic [31:0] exp_rd;
  logic        exp_irq;

  logic [31:0] offs [12] = '{32'h10, 32'h14, 32'h40, 32'h60, 32'h80, 32'h84,
                             32'h88, 32'h90, 32'hC0, 32'hD0, 32'hE0, 32'hE4};

  board_irq_ctrl #(.ADDR_W(ADDR_W), .N_IRQ(16)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .irq_in(irq_in), .rd_data(rd_data), .irq_out(irq_out)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic int gp_slot(input logic [31:0] a);
    for (int i = 0; i < 8; i++) if (offs[i] == a) return i;
    return -1;
  endfunction

  function automatic logic [31:0] model_read(input logic [31:0] a);
    int k;
    k = gp_slot(a);
    if (k >= 0) return m_gp[k];
    if (a == 32'hC0) return m_mask;
    if (a == 32'hD0) return m_pend;
    if (a == 32'hE0) return m_sock[0];
    if (a == 32'hE4) return m_sock[1];
    return 32'h0;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_gp[i] = '0;
    m_mask = '0; m_pend = '0; m_prev = '0;
    m_sock[0] = 32'h420; m_sock[1] = 32'h420;
  endtask

  task automatic model_clock(input bit wr, input logic [31:0] a, input logic [31:0] d,
                             input logic [15:0] irq);
    logic [31:0] rise;
    int k;
    exp_rd  = model_read(a);
    exp_irq = |(m_pend & m_mask);
    rise = {16'h0, irq & ~m_prev & m_mask[15:0]};
    m_pend = (wr && a == 32'hD0) ? ((d & KEEP) | rise) : (m_pend | rise);
    if (wr && a == 32'hC0) m_mask = d & KEEP;
    k = gp_slot(a);
    if (wr && k >= 0) m_gp[k] = d;
    m_sock[0][5] = ~irq[9];
    m_sock[1][5] = ~irq[13];
    if (wr && a == 32'hE0) m_sock[0][4:0] = d[4:0];
    if (wr && a == 32'hE4) m_sock[1][4:0] = d[4:0];
    m_prev = irq;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit wr, input logic [31:0] a,
                      input logic [31:0] d, input logic [15:0] irq);
    bus_wr = wr; bus_addr = a[ADDR_W-1:0]; bus_wdata = d; irq_in = irq;
    @(posedge clk);
    model_clock(wr, a, d, irq);
    @(negedge clk);
    check({tag, " rd_data"}, rd_data, exp_rd);
    check({tag, " irq_out"}, 32'(irq_out), 32'(exp_irq));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R1..all actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] irq;
    void'($urandom(32'd2718));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs during reset
    check("R1 rd_data in reset", rd_data, 32'h0);
    check("R1 irq_out in reset", 32'(irq_out), 32'h0);
    rst = 1'b0;
    for (int i = 0; i < 12; i++) step("R1 reset value", 1'b0, offs[i], 32'h0, 16'h0);
    step("R1 socket1", 1'b0, 32'hE4, 32'h0, 16'h0);
    check("R1 socket1 reset 0x420", rd_data, 32'h420);

    // R2: plain storage
    for (int i = 0; i < 8; i++) step("R2 write", 1'b1, offs[i], 32'hA5A5_0000 + 32'(i * 17), 16'h0);
    for (int i = 0; i < 8; i++) step("R2 read", 1'b0, offs[i], 32'h0, 16'h0);
    check("R2 last word", rd_data, 32'hA5A5_0000 + 32'(7 * 17));

    // R3: write and read on the same edge shows old value
    step("R3 wr+rd", 1'b1, 32'h60, 32'h1234_5678, 16'h0);
    check("R3 old value", rd_data, 32'hA5A5_0000 + 32'(3 * 17));
    step("R3 new value", 1'b0, 32'h60, 32'h0, 16'h0);
    check("R3 new value", rd_data, 32'h1234_5678);

    // R10: unmapped write and read
    step("R10 wr unmapped", 1'b1, 32'h44, 32'hFFFF_FFFF, 16'h0);
    step("R10 wr unmapped", 1'b1, 32'h100, 32'hFFFF_FFFF, 16'h0);
    step("R10 rd unmapped", 1'b0, 32'h44, 32'h0, 16'h0);
    check("R10 unmapped reads 0", rd_data, 32'h0);
    for (int i = 0; i < 12; i++) step("R10 map intact", 1'b0, offs[i], 32'h0, 16'h0);

    // R5: keep filter
    step("R5 mask all", 1'b1, 32'hC0, 32'hFFFF_FFFF, 16'h0);
    step("R5 rd mask", 1'b0, 32'hC0, 32'h0, 16'h0);
    check("R5 mask filtered", rd_data, 32'h000F_EEFF);
    step("R5 pend all", 1'b1, 32'hD0, 32'hFFFF_FFFF, 16'h0);
    step("R5 rd pend", 1'b0, 32'hD0, 32'h0, 16'h0);
    check("R5 pend filtered", rd_data, 32'h000F_EEFF);
    check("R7 irq with pend&mask", 32'(irq_out), 32'h1);
    step("R6 pend clear", 1'b1, 32'hD0, 32'h0, 16'h0);
    step("R7 irq drops", 1'b0, 32'hD0, 32'h0, 16'h0);
    step("R7 irq low", 1'b0, 32'hD0, 32'h0, 16'h0);
    check("R7 irq cleared", 32'(irq_out), 32'h0);

    // R4: disabled line does not latch
    step("R4 mask none", 1'b1, 32'hC0, 32'h0, 16'h0);
    step("R4 rise disabled", 1'b0, 32'hD0, 32'h0, 16'h0008);
    step("R4 rd pend", 1'b0, 32'hD0, 32'h0, 16'h0008);
    check("R4 disabled no latch", rd_data, 32'h0);
    step("R4 enable while high", 1'b1, 32'hC0, 32'h0000_0008, 16'h0008);
    step("R4 level no edge", 1'b0, 32'hD0, 32'h0, 16'h0008);
    step("R4 rd pend", 1'b0, 32'hD0, 32'h0, 16'h0008);
    check("R4 level alone no latch", rd_data, 32'h0);
    step("R4 drop", 1'b0, 32'hD0, 32'h0, 16'h0000);
    step("R4 rise enabled", 1'b0, 32'hD0, 32'h0, 16'h0008);
    check("R7 irq not yet", 32'(irq_out), 32'h0);
    step("R4 rd pend", 1'b0, 32'hD0, 32'h0, 16'h0008);
    check("R4 latched bit3", rd_data, 32'h8);
    check("R7 irq one cycle later", 32'(irq_out), 32'h1);
    // mask write coinciding with a rise does not enable that rise
    step("R4 clear", 1'b1, 32'hD0, 32'h0, 16'h0000);
    step("R4 mask+rise", 1'b1, 32'hC0, 32'h0000_0018, 16'h0010);
    step("R4 rd pend", 1'b0, 32'hD0, 32'h0, 16'h0010);
    check("R4 same-edge enable no latch", rd_data, 32'h0);
    // bit 8 can never be enabled
    step("R5 rise line8", 1'b1, 32'hC0, 32'h0000_0100, 16'h0100);
    step("R5 rd pend", 1'b0, 32'hD0, 32'h0, 16'h0000);
    check("R5 line8 never latches", rd_data, 32'h0);

    // R6: pending write collides with rise
    step("R6 enable 2", 1'b1, 32'hC0, 32'h0000_0004, 16'h0000);
    step("R6 clear+rise", 1'b1, 32'hD0, 32'h0000_0001, 16'h0004);
    step("R6 rd pend", 1'b0, 32'hD0, 32'h0, 16'h0004);
    check("R6 latch wins over write", rd_data, 32'h0000_0005);

    // R8 and R9: socket detect and control
    step("R8 line9 high", 1'b0, 32'hE0, 32'h0, 16'h0200);
    step("R8 rd sock0", 1'b0, 32'hE0, 32'h0, 16'h0200);
    check("R8 sock0 detect cleared", rd_data, 32'h400);
    step("R8 line13 high", 1'b0, 32'hE4, 32'h0, 16'h2000);
    step("R8 rd sock1", 1'b0, 32'hE4, 32'h0, 16'h2000);
    check("R8 sock1 detect cleared", rd_data, 32'h400);
    step("R9 wr sock1", 1'b1, 32'hE4, 32'hFFFF_FFFF, 16'h0000);
    step("R9 rd sock1", 1'b0, 32'hE4, 32'h0, 16'h0000);
    check("R9 only ctrl bits", rd_data, 32'h43F);
    step("R9 wr sock0", 1'b1, 32'hE0, 32'hFFFF_FFE0, 16'h0000);
    step("R9 rd sock0", 1'b0, 32'hE0, 32'h0, 16'h0000);
    check("R9 ctrl cleared upper kept", rd_data, 32'h420);

    // random mix: R3 R4 R6 R7 R8
    irq = 16'h0;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, d;
      bit wr;
      int pick;
      pick = int'($urandom_range(0, 15));
      a = (pick < 12) ? offs[pick] : (32'($urandom_range(0, 255)) & 32'hFFC);
      if (pick >= 8 && pick <= 9 && $urandom_range(0, 1) == 1) a = offs[pick];
      wr = ($urandom_range(0, 2) == 0);
      d = $urandom();
      irq = irq ^ (16'($urandom()) & 16'($urandom()) & 16'($urandom()));
      step("R4 R6 R7 R8 random", wr, a, d, irq);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule